// File: doc/BRIEF.md
# PHY Calibration Write Sequencer

After a PHY leaves reset, a few of its internal tuning registers have to be changed before high-speed links work reliably. This block carries out that change. A single start pulse makes it issue three writes, one after another, through a control-register port master. The first write overrides the loss-of-signal detector. The second raises the transmit voltage boost. The third sets the receiver-detect measurement time, and its value depends on the frequency of the reference clock.

The reference-clock selection is captured when the start pulse arrives. The sequencer then walks through the steps in order. Before each new step it waits for the port master to report that the previous write is done. If the port master reports an error on any write, the sequence stops there. At the end the block raises a one-cycle completion pulse, a pass flag, and a code that names the step that failed.

Top module: `phy_cal_seq`

## Requirements
- R1: The first write goes to address 0x0015 with data 0xA409: bias 5 in bits 15:13, override enable in bit 10 and level 9 in bits 4:0.
- R2: The second write goes to address 0x0012 with data 0xA000, which is boost level 5 in bits 15:13.
- R3: The third write goes to address 0x1010 with data equal to a measurement field shifted left by 4. The field is chosen by the 3-bit code `refclk_sel`: 0 (19.2 MHz) and 1 (20 MHz) give 0x04, 2 (24 MHz) and 3 (25/26 MHz) give 0x08, 4 (48/50/52 MHz) and 5 (62.5 MHz) give 0x20, 6 (96/100 MHz) gives 0x40, and 7 (unlisted) gives 0x08.
- R4: The writes are issued strictly in the order 1, 2, 3. A new `wr_req` rises only after the previous write's `wr_done`, and `wr_req` is low for at least one cycle between writes.
- R5: `wr_req` stays high, with `wr_addr` and `wr_data` stable, until the cycle in which `wr_done` is seen.
- R6: If `wr_done` arrives together with `wr_err`, no further write is issued. `cal_done` then pulses with `cal_pass`=0 and `cal_fail_step` equal to the step number (1, 2 or 3).
- R7: When all three writes complete without error, `cal_done` pulses for exactly one cycle with `cal_pass`=1 and `cal_fail_step`=0. Both values are held until the next completion.
- R8: A `start` pulse that arrives while a sequence is running is ignored.
- R9: `refclk_sel` is sampled only in the cycle that `start` is accepted. A later change has no effect on the third write.
- R10: After reset, `wr_req`, `cal_done`, `cal_pass` and `cal_fail_step` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that starts the calibration sequence |
| refclk_sel | input | 3 | Reference-clock frequency code |
| wr_req | output | 1 | Write request to the port master, held until done |
| wr_addr | output | 16 | Register address for the current write |
| wr_data | output | 16 | Data for the current write |
| wr_done | input | 1 | Port master reports that the write has finished (one-cycle pulse) |
| wr_err | input | 1 | Port master reports that the write failed; valid together with `wr_done` |
| cal_done | output | 1 | One-cycle pulse when the sequence ends |
| cal_pass | output | 1 | 1 when all three writes succeeded |
| cal_fail_step | output | 2 | Failed step number (1 to 3), or 0 on success |

## Verification
The bench drives all eight clock codes. This catches a wrong mapping of the third write's field, such as treating code 7 like 0 or mixing up the 62.5 MHz and 96 MHz entries. It injects an error at each of the three steps. A design that ignored the error would issue surplus writes, which the scoreboard sees as requests arriving with nothing expected. A design that reported the wrong step would show up in the fail code. The bench also sends a second start, with a different clock code, while a sequence is busy. A sequencer that re-sampled the code or restarted would show the wrong third data word or repeat the first write. Port-master latencies of one to four cycles show whether the request drops early or the address changes while a write is in flight.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  // Receiver-detect measurement field, indexed by the reference clock code.
  function automatic logic [6:0] rxdet_field(input logic [2:0] sel);
    case (sel)
      3'd0, 3'd1: rxdet_field = 7'h04;
      3'd2, 3'd3: rxdet_field = 7'h08;
      3'd4, 3'd5: rxdet_field = 7'h20;
      3'd6:       rxdet_field = 7'h40;
      default:    rxdet_field = 7'h08;
    endcase
  endfunction

endpackage

// File: rtl/phy_cal_word_sel.sv
module phy_cal_word_sel #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3,
  parameter int STEP_W = 2
) (
  input  logic [STEP_W-1:0] step,
  input  logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  import phy_cal_pkg::*;

  localparam int FIELD_LSB = 4;

  logic [DATA_W-1:0] meas_word;

  always_comb begin
    meas_word = '0;
    meas_word[FIELD_LSB +: 7] = rxdet_field(sel[2:0]);
  end

  always_comb begin
    case (step)
      2'd0: begin
        addr = ADDR_W'(16'h0015);
        data = DATA_W'({3'd5, 2'b00, 1'b1, 5'b00000, 5'd9});
      end
      2'd1: begin
        addr = ADDR_W'(16'h0012);
        data = DATA_W'({3'd5, 13'd0});
      end
      default: begin
        addr = ADDR_W'(16'h1010);
        data = meas_word;
      end
    endcase
  end

endmodule

// File: rtl/phy_cal_fsm.sv
module phy_cal_fsm #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3,
  parameter int STEPS  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [SEL_W-1:0]          sel_in,
  output logic [SEL_W-1:0]          sel_q,
  output logic [$clog2(STEPS+1)-1:0] step_q,
  input  logic [ADDR_W-1:0]         next_addr,
  input  logic [DATA_W-1:0]         next_data,
  output logic                      req_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [DATA_W-1:0]         data_o,
  input  logic                      done_i,
  input  logic                      err_i,
  output logic                      fin_o,
  output logic                      pass_o,
  output logic [$clog2(STEPS+1)-1:0] fail_o
);
  import phy_cal_pkg::*;

  localparam int STEP_W = $clog2(STEPS + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sel_q  <= '0;
      step_q <= '0;
      req_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      fin_o  <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= '0;
    end else begin
      fin_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            sel_q  <= sel_in;
            step_q <= '0;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          req_o  <= 1'b1;
          addr_o <= next_addr;
          data_o <= next_data;
          state  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (done_i) begin
            req_o <= 1'b0;
            if (err_i) begin
              fin_o  <= 1'b1;
              pass_o <= 1'b0;
              fail_o <= step_q + 1'b1;
              state  <= ST_IDLE;
            end else if (step_q == LAST) begin
              fin_o  <= 1'b1;
              pass_o <= 1'b1;
              fail_o <= '0;
              state  <= ST_IDLE;
            end else begin
              step_q <= step_q + 1'b1;
              state  <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: request, address and data held until the port master answers
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (req_o && !done_i) |=> (req_o && $stable(addr_o) && $stable(data_o)));

  // R6: a failed write ends the sequence with no further request
  assert_abort_on_err_R6: assert property (@(posedge clk) disable iff (rst)
    (req_o && done_i && err_i) |=> (!req_o && fin_o && !pass_o));

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> !fin_o);

  // R7: pass flag and failure code agree at completion
  assert_result_consistent_R7: assert property (@(posedge clk) disable iff (rst)
    fin_o |-> (pass_o == (fail_o == '0)));

  // R4: request drops for at least one cycle after each answered write
  assert_req_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (req_o && done_i) |=> !req_o);

  // R8: the latched clock code does not change while a sequence runs
  assert_sel_held_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(sel_q));

endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  refclk_sel,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_done,
  input  logic              wr_err,
  output logic              cal_done,
  output logic              cal_pass,
  output logic [1:0]        cal_fail_step
);
  localparam int STEPS  = 3;
  localparam int STEP_W = $clog2(STEPS + 1);

  logic [SEL_W-1:0]  sel_q;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] next_addr;
  logic [DATA_W-1:0] next_data;
  logic [STEP_W-1:0] fail_code;

  phy_cal_word_sel #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .STEP_W(STEP_W)
  ) u_word (
    .step(step_q),
    .sel (sel_q),
    .addr(next_addr),
    .data(next_data)
  );

  phy_cal_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .STEPS(STEPS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sel_in   (refclk_sel),
    .sel_q    (sel_q),
    .step_q   (step_q),
    .next_addr(next_addr),
    .next_data(next_data),
    .req_o    (wr_req),
    .addr_o   (wr_addr),
    .data_o   (wr_data),
    .done_i   (wr_done),
    .err_i    (wr_err),
    .fin_o    (cal_done),
    .pass_o   (cal_pass),
    .fail_o   (fail_code)
  );

  assign cal_fail_step = fail_code;

endmodule

// File: tb/phy_cal_seq_tb_top.sv
module phy_cal_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  refclk_sel = 3'd0;
  logic        wr_req;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        wr_done = 1'b0;
  logic        wr_err = 1'b0;
  logic        cal_done;
  logic        cal_pass;
  logic [1:0]  cal_fail_step;

  always #4 clk = ~clk;

  phy_cal_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .refclk_sel(refclk_sel),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .wr_err(wr_err),
    .cal_done(cal_done), .cal_pass(cal_pass), .cal_fail_step(cal_fail_step)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] wq[$];
  logic [2:0]  rq[$];
  int fail_at = 0;
  int lat = 1;
  int wr_idx = 0;
  int res_seen = 0;
  bit finished = 0;

  function automatic logic [15:0] exp_meas(input logic [2:0] s);
    case (s)
      3'd0, 3'd1: return 16'h0040;
      3'd2, 3'd3, 3'd7: return 16'h0080;
      3'd4, 3'd5: return 16'h0200;
      default: return 16'h0400;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Port-master model and write scoreboard (R1 R2 R3 R4 R5)
  initial begin
    forever begin
      @(negedge clk);
      if (wr_req && !rst) begin
        logic [31:0] got;
        logic [31:0] exp;
        got = {wr_addr, wr_data};
        wr_idx++;
        if (wq.size() == 0) begin
          check(0, "R4/R6 unexpected write", got, 32'h0);
        end else begin
          exp = wq.pop_front();
          check(got == exp, "R1/R2/R3/R4 write", got, exp);
        end
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          check(wr_req && {wr_addr, wr_data} == got, "R5 hold", {wr_addr, wr_data}, got);
        end
        wr_done = 1'b1;
        wr_err  = (wr_idx == fail_at);
        @(negedge clk);
        wr_done = 1'b0;
        wr_err  = 1'b0;
        check(!wr_req, "R4 gap", {31'd0, wr_req}, 32'd0);
      end
    end
  end

  // Result monitor (R6 R7)
  initial begin
    forever begin
      @(negedge clk);
      if (cal_done && !rst) begin
        logic [2:0] exp;
        exp = (rq.size() != 0) ? rq.pop_front() : 3'b111;
        check({cal_pass, cal_fail_step} == exp, "R6/R7 result",
              {29'd0, cal_pass, cal_fail_step}, {29'd0, exp});
        @(negedge clk);
        check(!cal_done, "R7 one-cycle pulse", {31'd0, cal_done}, 32'd0);
        check({cal_pass, cal_fail_step} == exp, "R7 result held",
              {29'd0, cal_pass, cal_fail_step}, {29'd0, exp});
        res_seen++;
      end
    end
  end

  task automatic run_seq(input logic [2:0] sel, input int fail_step, input int latency,
                         input bit busy_start);
    int base;
    wq.push_back({16'h0015, 16'hA409});
    if (fail_step != 1) wq.push_back({16'h0012, 16'hA000});
    if (fail_step != 1 && fail_step != 2) wq.push_back({16'h1010, exp_meas(sel)});
    rq.push_back(fail_step == 0 ? 3'b100 : {1'b0, 2'(fail_step)});
    fail_at = fail_step;
    lat = latency;
    wr_idx = 0;
    base = res_seen;
    @(negedge clk);
    refclk_sel = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    refclk_sel = ~sel;  // R9: later changes must not matter
    if (busy_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;      // R8: ignored while running
      @(negedge clk);
      start = 1'b0;
    end
    while (res_seen == base) @(negedge clk);
    repeat (6) @(negedge clk);
    check(!wr_req, "R6/R8 no trailing write", {31'd0, wr_req}, 32'd0);
    check(wq.size() == 0, "R4/R6 all writes issued", wq.size(), 0);
    wq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({wr_req, cal_done, cal_pass, cal_fail_step} == 5'b0, "R10 reset state",
          {27'd0, wr_req, cal_done, cal_pass, cal_fail_step}, 32'd0);
    for (int s = 0; s < 8; s++) run_seq(3'(s), 0, 1 + (s % 4), 1'b0);  // R3
    run_seq(3'd4, 1, 2, 1'b0);  // R6 step 1
    run_seq(3'd6, 2, 1, 1'b0);  // R6 step 2
    run_seq(3'd0, 3, 3, 1'b0);  // R6 step 3
    run_seq(3'd5, 0, 3, 1'b1);  // R8 R9
    run_seq(3'd1, 3, 2, 1'b1);  // R8 with failure
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule